// File: doc/BRIEF.md
# Fractional-Prescaler UART Rate Generator

This block turns a fixed 62.5 MHz reference clock into the two timing strobes a UART needs. A sample tick marks each period of the receiver's sampling rate, and a bit tick marks each bit period. Three stages form a chain.

- **Fractional prescaler.** It divides the reference in steps of one eighth, from 1.000 to 63.875. An accumulator adds 8 on every reference cycle. Whenever the sum reaches the prescaler code, the accumulator emits a pulse and subtracts the code.
- **Integer divisor.** A 16-bit counter counts prescaler pulses.
- **Oversampling counter.** It counts sample ticks and uses a ratio from 4 to 16.

The top speed is 62.5 MHz / 1 / 1 / 4 = 15.625 Mbit/s. As an example, a prescaler of 62.5 (code 500), a divisor of 1250 and a ratio of 16 give 50 bit/s.

A small controller state machine guards the chain. It has two named states:

- `ST_RELOAD` holds every counter at zero and suppresses all ticks.
- `ST_RUN` lets the chain count.

It has two named transitions:

- `T_START` goes from `ST_RELOAD` to `ST_RUN` unconditionally.
- `T_RESYNC` goes from `ST_RUN` to `ST_RELOAD` whenever any setting input differs from its value in the previous cycle.

In the cycle where a setting changes, the ticks are suppressed and the counters clear. The following cycle is spent in `ST_RELOAD`. The first counting cycle under the new settings is therefore two cycles after the change.

Top module: `uart_rate_gen`

## Requirements
- R1: The prescaler code is a 9-bit count of eighths. With an effective code E, the n-th prescaler pulse falls in counting cycle ceil(8n... more precisely, it falls in the first cycle c (counted from 0) for which 8·(c+1) ≥ n·E. The average period is therefore E/8 reference cycles.
- R2: When `pre_en` is 0, the prescaler is bypassed (E = 8, one pulse per cycle), whatever the value of `pre_code`.
- R3: With `pre_en` at 1, a `pre_code` below 8 is clamped to E = 8.
- R4: `div_val` gives the number D of prescaler pulses per sample period, and a value of 0 means D = 65536. The k-th sample tick falls in counting cycle ceil(k·D·E/8) − 1.
- R5: `os_code` selects the oversampling ratio R as follows: 0 selects 16, values 1 to 3 clamp to 4, and values 4 to 15 select themselves.
- R6: The k-th bit tick falls in counting cycle ceil(k·D·R·E/8) − 1, and every bit tick coincides with a sample tick.
- R7: In the cycle in which any setting changes, and in the cycle after it, both ticks are low. Counting then restarts from zero with the new settings, so counting cycle 0 is the second cycle after the change.
- R8: While `rst_n` is low, both ticks are low. The first cycle after reset release is spent reloading, and counting cycle 0 is the cycle after that.
- R9: With E = 8, D = 1 and R = 4, the sample tick is high in every counting cycle and the bit tick is high in every fourth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 62.5 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_code | input | 9 | Prescaler value in eighths |
| pre_en | input | 1 | 1 uses the prescaler; 0 bypasses it |
| div_val | input | 16 | Integer divisor (0 means 65536) |
| os_code | input | 4 | Oversampling ratio code |
| sample_tick | output | 1 | One-cycle strobe per sample period |
| bit_tick | output | 1 | One-cycle strobe per bit period |

## Verification
The sample tick and the bit tick fall in the same cycle at the end of every oversampling period. A settings change can also land in a cycle where the previous settings would have produced both ticks. Both coincidences are provoked by configurations with short periods, such as the fastest setting, followed immediately by a change. A scoreboard holds the expected cycle indices in two independent queues, computed from the closed-form formulas above. A tick is judged by matching it against its own queue, so a missing, extra or misplaced strobe on either output is reported separately. The two-cycle silence after a change is judged the same way, because no expected entry exists in those cycles.

// File: rtl/urg_pkg.sv
package urg_pkg;
    typedef enum logic [0:0] {
        ST_RELOAD = 1'b0,
        ST_RUN    = 1'b1
    } urg_state_e;
endpackage

// File: rtl/urg_ctrl.sv
module urg_ctrl #(
    parameter int CFG_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    output logic             run
);
    import urg_pkg::*;

    urg_state_e       state_q;
    urg_state_e       state_d;
    logic [CFG_W-1:0] cfg_q;
    logic             changed;

    assign changed = (cfg != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RELOAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg;
        end
    end

    // Transitions: T_START (reload -> run), T_RESYNC (run -> reload on change)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RELOAD: state_d = ST_RUN;
            ST_RUN:    if (changed) state_d = ST_RELOAD;
            default:   state_d = ST_RELOAD;
        endcase
    end

    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_RELOAD: run = 1'b0;
            ST_RUN:    run = !changed;
            default:   run = 1'b0;
        endcase
    end

    assert_reload_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELOAD) |=> (state_q == ST_RUN));
endmodule

// File: rtl/urg_prescale.sv
module urg_prescale #(
    parameter int PRE_W     = 9,
    parameter int FRAC_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] eff_code,
    output logic             pulse
);
    localparam int ACC_W = PRE_W + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(1 << FRAC_BITS);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] code_ext;

    assign code_ext = {1'b0, eff_code};
    assign sum      = acc_q + STEP;
    assign pulse    = run && (sum >= code_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!run) begin
            acc_q <= '0;
        end else if (pulse) begin
            acc_q <= sum - code_ext;
        end else begin
            acc_q <= sum;
        end
    end

    assert_acc_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc_q < code_ext));
endmodule

// File: rtl/urg_modcnt.sv
module urg_modcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = run && adv && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R4 / R5: count never passes its terminal value while counting
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last));
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
    parameter int PRE_W     = 9,
    parameter int FRAC_BITS = 3,
    parameter int DIV_W     = 16,
    parameter int OS_W      = 4,
    parameter int OS_MIN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_code,
    input  logic             pre_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [OS_W-1:0]  os_code,
    output logic             sample_tick,
    output logic             bit_tick
);
    localparam int CFG_W = PRE_W + 1 + DIV_W + OS_W;
    localparam logic [PRE_W-1:0] MIN_CODE = PRE_W'(1 << FRAC_BITS);

    logic [CFG_W-1:0] cfg;
    logic             run;
    logic [PRE_W-1:0] eff_code;
    logic             pre_pulse;
    logic [DIV_W-1:0] div_last;
    logic [OS_W-1:0]  os_last;

    assign cfg      = {pre_code, pre_en, div_val, os_code};
    assign eff_code = (!pre_en || (pre_code < MIN_CODE)) ? MIN_CODE : pre_code;
    assign div_last = div_val - 1'b1;   // 0 wraps to all ones: 65536 steps

    always_comb begin
        if (os_code == '0) begin
            os_last = '1;
        end else if (os_code < OS_W'(OS_MIN)) begin
            os_last = OS_W'(OS_MIN - 1);
        end else begin
            os_last = os_code - 1'b1;
        end
    end

    urg_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg),
        .run   (run)
    );

    urg_prescale #(.PRE_W(PRE_W), .FRAC_BITS(FRAC_BITS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .eff_code (eff_code),
        .pulse    (pre_pulse)
    );

    urg_modcnt #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .adv   (pre_pulse),
        .last  (div_last),
        .wrap  (sample_tick)
    );

    urg_modcnt #(.W(OS_W)) u_os (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .adv   (sample_tick),
        .last  (os_last),
        .wrap  (bit_tick)
    );

    assert_bit_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    assert_bypass_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pre_en) |-> pre_pulse);

    assert_fastest_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && eff_code == MIN_CODE && div_val == DIV_W'(1)) |-> sample_tick);

    assert_change_mutes_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |-> (!sample_tick && !bit_tick));

    assert_change_mutes_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/uart_rate_gen_bench.sv
module uart_rate_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  pre_code = '0;
    logic        pre_en = 1'b0;
    logic [15:0] div_val = '0;
    logic [3:0]  os_code = '0;
    logic        sample_tick;
    logic        bit_tick;

    int     total = 0;
    int     bad = 0;
    longint ncyc = 0;
    longint sq[$];
    longint bq[$];
    int     s_hit = 0;
    int     b_hit = 0;
    string  cur_tag = "R8";

    always #5 clk = ~clk;

    uart_rate_gen u_uart_rate_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .pre_code    (pre_code),
        .pre_en      (pre_en),
        .div_val     (div_val),
        .os_code     (os_code),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    // Monitor: compare observed ticks against the expected queues
    always @(negedge clk) begin
        if (sample_tick) begin
            if (sq.size() == 0 || sq[0] != ncyc) begin
                bad++;
                $display("FAIL %s sample tick at cycle %0d, expected %0d", cur_tag, ncyc,
                         (sq.size() != 0) ? sq[0] : -1);
            end else begin
                void'(sq.pop_front());
                s_hit++;
                total++;
            end
        end
        while (sq.size() != 0 && sq[0] <= ncyc) begin
            bad++;
            $display("FAIL %s sample tick missing: actual none, expected %0d", cur_tag, sq[0]);
            void'(sq.pop_front());
        end
        if (bit_tick) begin
            if (bq.size() == 0 || bq[0] != ncyc) begin
                bad++;
                $display("FAIL %s bit tick at cycle %0d, expected %0d", cur_tag, ncyc,
                         (bq.size() != 0) ? bq[0] : -1);
            end else begin
                void'(bq.pop_front());
                b_hit++;
                total++;
            end
        end
        while (bq.size() != 0 && bq[0] <= ncyc) begin
            bad++;
            $display("FAIL %s bit tick missing: actual none, expected %0d", cur_tag, bq[0]);
            void'(bq.pop_front());
        end
        ncyc++;
    end

    function automatic longint eff_of(int code, bit en);
        return (!en || code < 8) ? 8 : code;
    endfunction

    function automatic longint ratio_of(int oc);
        if (oc == 0) return 16;
        if (oc < 4) return 4;
        return oc;
    endfunction

    // Driver: apply settings and push expected tick cycles
    task automatic run_case(input int code, input bit en, input int dv, input int oc,
                            input longint win, input string tag, input bit from_reset);
        longint base;
        longint e;
        longint d;
        longint r;
        int     s_exp;
        int     b_exp;
        e = eff_of(code, en);
        d = (dv == 0) ? 65536 : dv;
        r = ratio_of(oc);
        @(posedge clk);
        #2;
        cur_tag = tag;
        if (from_reset) begin
            rst_n = 1'b1;
            base  = ncyc + 1;
        end else begin
            pre_code = 9'(code);
            pre_en   = en;
            div_val  = 16'(dv);
            os_code  = 4'(oc);
            base     = ncyc + 2;
        end
        s_hit = 0;
        b_hit = 0;
        s_exp = 0;
        b_exp = 0;
        for (longint k = 1; ; k++) begin
            longint c;
            c = (k * d * e + 7) / 8 - 1;
            if (c >= win) break;
            sq.push_back(base + c);
            s_exp++;
        end
        for (longint k = 1; ; k++) begin
            longint c;
            c = (k * d * r * e + 7) / 8 - 1;
            if (c >= win) break;
            bq.push_back(base + c);
            b_exp++;
        end
        wait (ncyc >= base + win);
        total++;
        if (s_hit != s_exp) begin
            bad++;
            $display("FAIL %s sample tick count %0d, expected %0d", tag, s_hit, s_exp);
        end
        total++;
        if (b_hit != b_exp) begin
            bad++;
            $display("FAIL %s bit tick count %0d, expected %0d", tag, b_hit, b_exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, actual hung, expected done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R8: reset holds both ticks low even with the fastest settings
        pre_code = 9'd8;
        pre_en   = 1'b1;
        div_val  = 16'd1;
        os_code  = 4'd4;
        repeat (3) begin
            @(negedge clk);
            total++;
            if (sample_tick || bit_tick) begin
                bad++;
                $display("FAIL R8 ticks during reset: actual %b%b, expected 00",
                         sample_tick, bit_tick);
            end
        end
        run_case(8, 1, 1, 4, 40, "R9", 1'b1);       // R8 release + R9 fastest rate
        run_case(12, 1, 3, 5, 400, "R6", 1'b0);     // 1.5 prescale, bit every 5 samples
        run_case(100, 0, 2, 6, 200, "R2", 1'b0);    // bypass ignores pre_code
        run_case(5, 1, 3, 0, 300, "R3", 1'b0);      // clamp below 1.0, ratio 16
        run_case(8, 1, 1, 2, 40, "R5", 1'b0);       // os code 2 clamps to 4
        run_case(9, 1, 7, 15, 2000, "R7", 1'b0);    // change right after fastest setting
        run_case(271, 1, 1, 0, 3000, "R1", 1'b0);   // 33.875 prescale
        run_case(511, 1, 2, 4, 6000, "R1", 1'b0);   // largest prescale 63.875
        run_case(8, 1, 0, 4, 131100, "R4", 1'b0);   // divisor 0 means 65536
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule